// File: doc/BRIEF.md
# Parallel Scan Chain Test Sequencer

This block runs a whole scan test on a sequential circuit whose flops are stitched into several parallel scan chains. The chains receive three things from it: a scan-enable select, a chain clock enable and one serial input bit per chain. Each chain flop takes its functional data when scan-enable is 0 and the previous flop's output when scan-enable is 1. It advances only while the clock enable is high. The sequencer first loads a stimulus pattern with scan-enable high. It then drops scan-enable for a single capture cycle. After that it unloads the captured response while the next stimulus shifts in over the same cycles. Every chain is compared in parallel against the expected response.

Stimulus, expected and care bits arrive as a valid/ready stream, one bit per chain per beat. A shift phase always takes `MAX_LEN` accepted beats, which is the length of the longest chain. A shorter chain is padded, and its padding beats are excluded through their care bits. Back-pressure works as follows. `s_ready` is high only during shift phases, and a beat is taken on a clock edge where `s_valid` and `s_ready` are both high. While `s_valid` is low, the chains hold with scan-enable still high. The producer must hold a beat stable until it is taken. The beats of each shift phase carry the stimulus for the current pattern together with the expected response of the previous pattern. The last phase unloads only, and its stimulus bits are don't-care.

Top module: `scan_test_seq`

## Requirements
- R1: While not busy, the chains run in functional mode: `scan_en`=0, `chain_ce`=1, `chain_si`=0 and `s_ready`=0.
- R2: A `start` seen while idle, or in the done cycle, latches `num_patterns` and raises `busy` in the next cycle. A `start`, or a change of `num_patterns`, while busy has no effect on the run.
- R3: In a shift phase `scan_en`=1 and `s_ready`=1. `chain_ce` equals `s_valid`, so the chains hold during a stall. `chain_si` carries `s_stim` bit for bit (bit i feeds chain i).
- R4: After the last beat of a phase, if patterns remain, there is exactly one capture cycle with `scan_en`=0, `chain_ce`=1 and `s_ready`=0, after which shifting resumes.
- R5: A run has `num_patterns` load phases plus one final unload-only phase, each of `MAX_LEN` accepted beats, and exactly `num_patterns` capture cycles. A count of 0 gives one shift phase and no capture.
- R6: On each accepted beat after the first phase, every chain i whose `s_care[i]`=1 and whose `chain_so[i]` differs from `s_expect[i]` sets `mismatch` and bit i of `fail_map`.
- R7: Nothing is compared during the first (load-only) phase, or on a chain whose care bit is 0.
- R8: `mismatch` and `fail_map` keep their values until the next accepted `start`, which clears both.
- R9: `done` is a one-cycle pulse in the cycle after the final phase's last beat. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run |
| num_patterns | input | PAT_W | Number of patterns in the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| s_valid | input | 1 | Stream beat present |
| s_ready | output | 1 | Stream beat accepted when valid |
| s_stim | input | NUM_CHAINS | Stimulus bit per chain |
| s_expect | input | NUM_CHAINS | Expected response bit per chain |
| s_care | input | NUM_CHAINS | Compare enable per chain |
| scan_en | output | 1 | Chain input select: 1 shift, 0 functional |
| chain_ce | output | 1 | Chain clock enable |
| chain_si | output | NUM_CHAINS | Serial input per chain |
| chain_so | input | NUM_CHAINS | Serial output per chain |
| mismatch | output | 1 | Sticky defect flag |
| fail_map | output | NUM_CHAINS | Sticky per-chain failure bits |

## Verification
Several rules are checked by the assertions on every cycle. They cover the functional-mode outputs while not busy, the tie between the clock enable and the stream handshake in shift phases, and the one-cycle width of the capture window. They also cover the single-cycle `done` pulse, the agreement between `mismatch` and `fail_map`, and the flags clearing only on an accepted start. Other behaviour only shows in the bench scenarios, where a chain model captures real responses. Those scenarios cover run length and capture count per pattern count, overlapped unload against the previous pattern's expected data, and skipped compares in the first phase and on padding beats. They also cover per-chain failure reporting, sticky flags, and an ignored mid-run start.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int MAX_LEN = 6,
  parameter int PAT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] num_patterns,
  input  logic             s_valid,
  output seq_state_e       state,
  output logic             start_ok,
  output logic             shift_fire,
  output logic             cmp_en,
  output logic             busy,
  output logic             done
);
  localparam int BIT_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(MAX_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [BIT_W-1:0] bit_cnt;
  logic [PAT_W-1:0] phase_cnt;
  logic [PAT_W-1:0] pat_total;
  logic             last_beat;

  assign state      = state_q;
  assign start_ok   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign shift_fire = (state_q == ST_SHIFT) && s_valid;
  assign last_beat  = shift_fire && (bit_cnt == LAST_BIT);
  assign cmp_en     = (phase_cnt != '0);
  assign busy       = (state_q == ST_SHIFT) || (state_q == ST_CAPT);
  assign done       = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_SHIFT;
      ST_SHIFT: if (last_beat) state_d = (phase_cnt == pat_total) ? ST_DONE : ST_CAPT;
      ST_CAPT:  state_d = ST_SHIFT;
      ST_DONE:  state_d = start_ok ? ST_SHIFT : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt   <= '0;
      phase_cnt <= '0;
      pat_total <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        bit_cnt   <= '0;
        phase_cnt <= '0;
        pat_total <= num_patterns;
      end else begin
        if (shift_fire) bit_cnt <= last_beat ? '0 : bit_cnt + 1'b1;
        if (state_q == ST_CAPT) phase_cnt <= phase_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_seq_drive.sv
module scan_seq_drive
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 4
) (
  input  seq_state_e            state,
  input  logic                  s_valid,
  input  logic [NUM_CHAINS-1:0] s_stim,
  output logic                  scan_en,
  output logic                  chain_ce,
  output logic                  s_ready,
  output logic [NUM_CHAINS-1:0] chain_si
);
  always_comb begin
    scan_en  = 1'b0;
    chain_ce = 1'b1;
    s_ready  = 1'b0;
    chain_si = '0;
    if (state == ST_SHIFT) begin
      scan_en  = 1'b1;
      s_ready  = 1'b1;
      chain_ce = s_valid;
      chain_si = s_stim;
    end
  end
endmodule

// File: rtl/scan_seq_cmp.sv
module scan_seq_cmp #(
  parameter int NUM_CHAINS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  fire,
  input  logic [NUM_CHAINS-1:0] so,
  input  logic [NUM_CHAINS-1:0] expect_bits,
  input  logic [NUM_CHAINS-1:0] care,
  output logic                  mismatch,
  output logic [NUM_CHAINS-1:0] fail_map
);
  logic [NUM_CHAINS-1:0] hit;

  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_chain
    assign hit[i] = fire && care[i] && (so[i] != expect_bits[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fail_map[i] <= 1'b0;
      else if (clear)  fail_map[i] <= 1'b0;
      else if (hit[i]) fail_map[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mismatch <= 1'b0;
    else if (clear) mismatch <= 1'b0;
    else if (|hit)  mismatch <= 1'b1;
  end
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 4,
  parameter int MAX_LEN    = 6,
  parameter int PAT_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [PAT_W-1:0]      num_patterns,
  output logic                  busy,
  output logic                  done,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [NUM_CHAINS-1:0] s_stim,
  input  logic [NUM_CHAINS-1:0] s_expect,
  input  logic [NUM_CHAINS-1:0] s_care,
  output logic                  scan_en,
  output logic                  chain_ce,
  output logic [NUM_CHAINS-1:0] chain_si,
  input  logic [NUM_CHAINS-1:0] chain_so,
  output logic                  mismatch,
  output logic [NUM_CHAINS-1:0] fail_map
);
  seq_state_e state;
  logic       start_ok;
  logic       shift_fire;
  logic       cmp_en;

  scan_seq_ctrl #(.MAX_LEN(MAX_LEN), .PAT_W(PAT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .num_patterns (num_patterns),
    .s_valid      (s_valid),
    .state        (state),
    .start_ok     (start_ok),
    .shift_fire   (shift_fire),
    .cmp_en       (cmp_en),
    .busy         (busy),
    .done         (done)
  );

  scan_seq_drive #(.NUM_CHAINS(NUM_CHAINS)) u_drive (
    .state    (state),
    .s_valid  (s_valid),
    .s_stim   (s_stim),
    .scan_en  (scan_en),
    .chain_ce (chain_ce),
    .s_ready  (s_ready),
    .chain_si (chain_si)
  );

  scan_seq_cmp #(.NUM_CHAINS(NUM_CHAINS)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start_ok),
    .fire        (shift_fire && cmp_en),
    .so          (chain_so),
    .expect_bits (s_expect),
    .care        (s_care),
    .mismatch    (mismatch),
    .fail_map    (fail_map)
  );
endmodule

// File: rtl/scan_test_seq_sva.sv
module scan_test_seq_sva #(
  parameter int NUM_CHAINS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic                  s_valid,
  input logic                  s_ready,
  input logic                  scan_en,
  input logic                  chain_ce,
  input logic                  mismatch,
  input logic [NUM_CHAINS-1:0] fail_map
);
  a_r1_functional_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scan_en && chain_ce && !s_ready));

  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r3_stall_holds_chains: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (scan_en && (chain_ce == s_valid)));

  a_r4_capture_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_en) |=> (busy && scan_en));

  a_r4_capture_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_en) |-> (chain_ce && !s_ready));

  a_r6_flag_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch == (|fail_map));

  a_r8_clear_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mismatch) |-> $past(start && !busy));

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind scan_test_seq scan_test_seq_sva #(.NUM_CHAINS(NUM_CHAINS)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .scan_en  (scan_en),
  .chain_ce (chain_ce),
  .mismatch (mismatch),
  .fail_map (fail_map)
);

// File: tb/scan_test_seq_tb.sv
module scan_test_seq_tb;
  localparam int N       = 4;
  localparam int MAX_LEN = 6;
  localparam int PAT_W   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [PAT_W-1:0] num_patterns = '0;
  logic             busy, done, s_ready, scan_en, chain_ce, mismatch;
  logic             s_valid = 1'b0;
  logic [N-1:0]     s_stim = '0, s_expect = '0, s_care = '0;
  logic [N-1:0]     chain_si, chain_so, fail_map;

  int n_checks = 0;
  int n_fail   = 0;
  int cap_count = 0;
  logic [N-1:0] si_q[$];
  logic [N-1:0] prev_stim [MAX_LEN];
  logic [N-1:0] cur_stim  [MAX_LEN];
  logic [MAX_LEN-1:0] ch [N] = '{default: '0};

  always #10 clk = ~clk;

  scan_test_seq #(.NUM_CHAINS(N), .MAX_LEN(MAX_LEN), .PAT_W(PAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_patterns(num_patterns),
    .busy(busy), .done(done), .s_valid(s_valid), .s_ready(s_ready),
    .s_stim(s_stim), .s_expect(s_expect), .s_care(s_care),
    .scan_en(scan_en), .chain_ce(chain_ce), .chain_si(chain_si),
    .chain_so(chain_so), .mismatch(mismatch), .fail_map(fail_map)
  );

  function automatic int chain_len(int c);
    case (c)
      0: return 6;
      1: return 6;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  // Chain model: shift when scan_en, otherwise functional next state ~q[(j+1)%L]
  always @(posedge clk) begin
    if (chain_ce) begin
      for (int c = 0; c < N; c++) begin
        automatic int len = chain_len(c);
        automatic logic [MAX_LEN-1:0] nx = ch[c];
        for (int j = 0; j < len; j++) begin
          if (scan_en) nx[j] = (j == 0) ? chain_si[c] : ch[c][j-1];
          else         nx[j] = ~ch[c][(j + 1) % len];
        end
        ch[c] <= nx;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < N; c++) chain_so[c] = ch[c][chain_len(c) - 1];
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected unload bit of chain c at beat k from the previously loaded pattern
  function automatic logic exp_bit(int c, int k);
    automatic int len = chain_len(c);
    automatic int pos = (len - k) % len;
    return ~prev_stim[MAX_LEN - 1 - pos][c];
  endfunction

  // Monitor: pops expected serial inputs and counts capture cycles
  always begin
    @(negedge clk);
    #5;
    if (rst_n && busy && scan_en && chain_ce) begin
      if (si_q.size() == 0) chk(1'b0, "R3 queue underflow", 32'(chain_si), 0);
      else begin
        automatic logic [N-1:0] e = si_q.pop_front();
        chk(chain_si == e, "R3 chain_si", 32'(chain_si), 32'(e));
      end
    end
    if (rst_n && busy && !scan_en) begin
      cap_count++;
      chk(chain_ce && !s_ready, "R4 capture outputs", {30'd0, chain_ce, s_ready}, 32'h2);
    end
  end

  task automatic run(input int npat, input int bad_pat, input int bad_chain, input int bad_beat,
                     input bit stall, input bit mid_start,
                     input logic exp_mis, input logic [N-1:0] exp_map);
    automatic int cap0;
    @(negedge clk);
    num_patterns = PAT_W'(npat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cap0 = cap_count;
    chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
    chk(mismatch == 1'b0 && fail_map == '0, "R8 cleared by start", {27'd0, mismatch, fail_map}, 0);
    for (int p = 0; p <= npat; p++) begin
      for (int k = 0; k < MAX_LEN; k++) begin
        automatic logic [N-1:0] ex = '0, ca = '0;
        if (stall && p == 1 && k == 2) begin
          s_valid = 1'b0;
          repeat (3) @(negedge clk);
          chk(chain_ce == 1'b0 && scan_en == 1'b1, "R3 stall holds", {30'd0, chain_ce, scan_en}, 1);
        end
        cur_stim[k] = N'($urandom);
        for (int c = 0; c < N; c++) begin
          if (p == 0) begin
            ex[c] = 1'($urandom);
            ca[c] = 1'b1;
          end else begin
            ca[c] = (k < chain_len(c));
            ex[c] = ca[c] ? exp_bit(c, k) : 1'($urandom);
          end
        end
        if (p == bad_pat && k == bad_beat) ex[bad_chain] = ~ex[bad_chain];
        start = (mid_start && p == 1 && k == 0);
        if (start) num_patterns = PAT_W'(npat + 3);
        s_valid  = 1'b1;
        s_stim   = cur_stim[k];
        s_expect = ex;
        s_care   = ca;
        si_q.push_back(cur_stim[k]);
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        start = 1'b0;
      end
      prev_stim = cur_stim;
    end
    s_valid = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R9 done pulse", {30'd0, done, busy}, 2);
    chk(cap_count - cap0 == npat, "R5 capture count", 32'(cap_count - cap0), 32'(npat));
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
    chk(!scan_en && chain_ce && !s_ready && chain_si == '0, "R1 functional after run",
        {28'd0, scan_en, chain_ce, s_ready, |chain_si}, 32'h4);
    chk(si_q.size() == 0, "R5 beats consumed", 32'(si_q.size()), 0);
    chk(mismatch == exp_mis, "R6 mismatch", 32'(mismatch), 32'(exp_mis));
    chk(fail_map == exp_map, "R6 fail_map", 32'(fail_map), 32'(exp_map));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL R9 watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mismatch && fail_map == '0, "R1 reset flags", {28'd0, busy, done, mismatch, |fail_map}, 0);
    chk(!scan_en && chain_ce && !s_ready && chain_si == '0, "R1 idle functional",
        {28'd0, scan_en, chain_ce, s_ready, |chain_si}, 32'h4);
    // clean run with stalls
    run(3, -1, 0, 0, 1'b1, 1'b0, 1'b0, 4'b0000);
    // R6: chain 2 bad on a care beat of pattern 1 unload
    run(2, 1, 2, 0, 1'b0, 1'b0, 1'b1, 4'b0100);
    repeat (5) @(negedge clk);
    chk(mismatch == 1'b1 && fail_map == 4'b0100, "R8 sticky while idle", {27'd0, mismatch, fail_map}, 32'h14);
    // R7: bad bit in the first phase is never compared; R2: mid-run start ignored
    run(2, 0, 1, 3, 1'b0, 1'b1, 1'b0, 4'b0000);
    // R7: chain 3 (length 5) beat 5 is padding, care=0
    run(2, 2, 3, 5, 1'b0, 1'b0, 1'b0, 4'b0000);
    // R6: chain 0 last beat in final unload
    run(1, 1, 0, 5, 1'b1, 1'b0, 1'b1, 4'b0001);
    // R5: zero patterns: one shift phase, no capture
    run(0, -1, 0, 0, 1'b0, 1'b0, 1'b0, 4'b0000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule